// File: doc/BRIEF.md
# Exception Frame Stacking Sequencer

This block moves a processor core into exception processing. When it receives a start request, it captures the core's program counter, status word and, for a fault, the opcode word, the faulting address and the bus-cycle status word. It then writes these items to the supervisor stack through a single-request memory port. The pointer is decremented before each write, by the size of the item being written.

When the frame is complete, the block fetches a 32-bit handler address from the vector table and hands it to the core as the new program counter. Along with it, the block supplies a status word with supervisor mode forced on and tracing forced off. One cycle after the new program counter is loaded, the block checks it for alignment.

The block keeps a fault-in-progress flag. A second fault that arrives while this flag is set is fatal: the block halts and does nothing more until reset. The core clears the flag once the handler's first instruction has been fetched.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `halt_o`, `odd_pc_o`, `mem_req_o`, `pc_load_o` and `clr_pending_o` are all low.
- R2: For an ordinary trap (`fault_i`=0), exactly two writes occur, in this order:
  - the PC as a long item (`mem_long_o`=1) at SSP-4;
  - the original SR as a word item (`mem_long_o`=0, zero-extended in `mem_wdata_o`) at SSP-6.
- R3: For a fault (`fault_i`=1), exactly five writes occur, in this order:
  - PC (long) at SSP-4;
  - SR (word) at SSP-6;
  - opcode word (word) at SSP-8;
  - fault address (long) at SSP-12;
  - cycle status word (word) at SSP-14.
- R4: Each write address equals the current stack pointer minus the item size (4 for a long item, 2 for a word item). At completion, `ssp_o` equals SSP-6 for a trap and SSP-14 for a fault.
- R5: `sr_o` equals the captured SR with bit 13 set and bit 15 cleared. The frame holds the SR exactly as it was captured.
- R6: After the frame is written, one long read (`mem_we_o`=0) is issued at vector×4. The read data appears on `pc_o`, and `pc_load_o` pulses for one cycle.
- R7: In the cycle after `pc_load_o`, `done_o` pulses for one cycle. In that same cycle, `odd_pc_o` equals bit 0 of the new PC, and it keeps that value until the next accepted start.
- R8: A fault start that arrives while the fault-in-progress flag is set raises `halt_o`, which stays high until reset. While halted, no memory request is made and `busy_o` stays low.
- R9: `clr_pending_o` pulses for one cycle after a fault start is accepted. It does not pulse for a trap start.
- R10: While a request is waiting for `mem_ack_i`, the request and its address, direction and write data are held stable.
- R11: `busy_o` rises in the cycle after the start is accepted and stays high through the `pc_load_o` cycle. A start received while busy is ignored.
- R12: `fetch_ok_i` clears the fault-in-progress flag, so a later fault is processed normally. A trap is processed normally even while the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Exception entry request |
| fault_i | input | 1 | 1 = bus/address fault frame, 0 = ordinary trap |
| vector_i | input | VEC_W | Vector number |
| pc_i | input | ADDR_W | Program counter to stack |
| sr_i | input | WORD_W | Status word to stack |
| ir_i | input | WORD_W | Opcode word (fault frame only) |
| fault_addr_i | input | ADDR_W | Faulting address (fault frame only) |
| cycle_info_i | input | WORD_W | Bus-cycle status word (fault frame only) |
| ssp_i | input | ADDR_W | Supervisor stack pointer at entry |
| fetch_ok_i | input | 1 | Handler's first fetch done; clears fault-in-progress flag |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_long_o | output | 1 | 1 = 4-byte item, 0 = 2-byte item |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | ADDR_W | Write data, word items in the low bits |
| mem_ack_i | input | 1 | Access complete |
| mem_rdata_i | input | ADDR_W | Read data |
| sr_o | output | WORD_W | Updated status word |
| pc_o | output | ADDR_W | New program counter |
| pc_load_o | output | 1 | One-cycle pulse: `pc_o` is valid |
| ssp_o | output | ADDR_W | Current stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| halt_o | output | 1 | Double fault: core halted |
| odd_pc_o | output | 1 | New PC was odd |
| clr_pending_o | output | 1 | Pulse: clear pending read/write/interrupt/locked-cycle flags |

## Verification
An accepted start takes effect at the next edge: `busy_o` and `clr_pending_o` are visible one cycle after the start is sampled, so the bench checks them at the following falling edge. Each memory access finishes on the edge where `mem_ack_i` is sampled high. The bench's memory model logs every access at the falling edge on which it raises the acknowledge, and compares the log with addresses computed from the entry stack pointer and the item sizes. `pc_load_o` and `pc_o` change on the edge that accepts the vector read. `done_o` and `odd_pc_o` appear one edge later, so the bench polls for `done_o` at falling edges and checks every result in that cycle. A double fault raises `halt_o` one edge after the start; the bench then waits ten cycles and confirms that no access was logged.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PUSH  = 3'd1,
        ST_VEC   = 3'd2,
        ST_CHECK = 3'd3,
        ST_HALT  = 3'd4
    } seq_state_e;

    // Push order is behaviour: index 0 is pushed first.
    localparam logic [2:0] ITEM_PC    = 3'd0;
    localparam logic [2:0] ITEM_SR    = 3'd1;
    localparam logic [2:0] ITEM_IR    = 3'd2;
    localparam logic [2:0] ITEM_FADDR = 3'd3;
    localparam logic [2:0] ITEM_CINFO = 3'd4;

    localparam logic [2:0] LAST_TRAP_ITEM  = ITEM_SR;
    localparam logic [2:0] LAST_FAULT_ITEM = ITEM_CINFO;

    localparam int SR_SUPER_BIT = 13;
    localparam int SR_TRACE_BIT = 15;

endpackage

// File: rtl/exc_item_sel.sv
module exc_item_sel
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 16
) (
    input  logic [2:0]        item_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [WORD_W-1:0] sr_i,
    input  logic [WORD_W-1:0] ir_i,
    input  logic [ADDR_W-1:0] faddr_i,
    input  logic [WORD_W-1:0] cinfo_i,
    output logic [ADDR_W-1:0] data_o,
    output logic              long_o
);
    always_comb begin
        data_o = '0;
        long_o = 1'b0;
        unique case (item_i)
            ITEM_PC: begin
                data_o = pc_i;
                long_o = 1'b1;
            end
            ITEM_SR:    data_o = ADDR_W'(sr_i);
            ITEM_IR:    data_o = ADDR_W'(ir_i);
            ITEM_FADDR: begin
                data_o = faddr_i;
                long_o = 1'b1;
            end
            ITEM_CINFO: data_o = ADDR_W'(cinfo_i);
            default: begin
                data_o = '0;
                long_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int VEC_W     = 8,
    parameter int VEC_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] sp_i,
    input  logic              long_i,
    input  logic [VEC_W-1:0]  vec_i,
    output logic [ADDR_W-1:0] push_addr_o,
    output logic [ADDR_W-1:0] vec_addr_o
);
    localparam logic [ADDR_W-1:0] LONG_BYTES = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

    assign push_addr_o = sp_i - (long_i ? LONG_BYTES : WORD_BYTES);

    generate
        if (VEC_SHIFT == 0) begin : g_noshift
            assign vec_addr_o = ADDR_W'(vec_i);
        end else begin : g_shift
            assign vec_addr_o = ADDR_W'({vec_i, {VEC_SHIFT{1'b0}}});
        end
    endgenerate
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 16,
    parameter int VEC_W     = 8,
    parameter int VEC_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              fault_i,
    input  logic [VEC_W-1:0]  vector_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [WORD_W-1:0] sr_i,
    input  logic [WORD_W-1:0] ir_i,
    input  logic [ADDR_W-1:0] fault_addr_i,
    input  logic [WORD_W-1:0] cycle_info_i,
    input  logic [ADDR_W-1:0] ssp_i,
    input  logic              fetch_ok_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_long_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [ADDR_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    output logic [WORD_W-1:0] sr_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] ssp_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              halt_o,
    output logic              odd_pc_o,
    output logic              clr_pending_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [2:0]        idx;
        logic              is_fault;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] pc_cap;
        logic [ADDR_W-1:0] fa_cap;
        logic [ADDR_W-1:0] pc_new;
        logic [WORD_W-1:0] sr_cap;
        logic [WORD_W-1:0] ir_cap;
        logic [WORD_W-1:0] ci_cap;
        logic [WORD_W-1:0] sr_new;
        logic [VEC_W-1:0]  vec;
        logic              fault_act;
        logic              halt;
        logic              done;
        logic              odd;
        logic              pc_load;
        logic              clr;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [ADDR_W-1:0] item_data;
    logic              item_long;
    logic [ADDR_W-1:0] push_addr;
    logic [ADDR_W-1:0] vec_addr;
    logic [2:0]        last_idx;
    logic [WORD_W-1:0] sr_forced;

    exc_item_sel #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_item (
        .item_i  (r_q.idx),
        .pc_i    (r_q.pc_cap),
        .sr_i    (r_q.sr_cap),
        .ir_i    (r_q.ir_cap),
        .faddr_i (r_q.fa_cap),
        .cinfo_i (r_q.ci_cap),
        .data_o  (item_data),
        .long_o  (item_long)
    );

    exc_addr_gen #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .VEC_SHIFT(VEC_SHIFT)) u_addr (
        .sp_i        (r_q.sp),
        .long_i      (item_long),
        .vec_i       (r_q.vec),
        .push_addr_o (push_addr),
        .vec_addr_o  (vec_addr)
    );

    assign last_idx = r_q.is_fault ? LAST_FAULT_ITEM : LAST_TRAP_ITEM;

    always_comb begin
        sr_forced               = sr_i;
        sr_forced[SR_SUPER_BIT] = 1'b1;
        sr_forced[SR_TRACE_BIT] = 1'b0;
    end

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.pc_load = 1'b0;
        r_d.clr     = 1'b0;
        if (fetch_ok_i) begin
            r_d.fault_act = 1'b0;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (fault_i && r_q.fault_act) begin
                        r_d.st   = ST_HALT;
                        r_d.halt = 1'b1;
                    end else begin
                        r_d.st       = ST_PUSH;
                        r_d.idx      = ITEM_PC;
                        r_d.is_fault = fault_i;
                        r_d.sp       = ssp_i;
                        r_d.pc_cap   = pc_i;
                        r_d.sr_cap   = sr_i;
                        r_d.ir_cap   = ir_i;
                        r_d.fa_cap   = fault_addr_i;
                        r_d.ci_cap   = cycle_info_i;
                        r_d.vec      = vector_i;
                        r_d.sr_new   = sr_forced;
                        r_d.odd      = 1'b0;
                        if (fault_i) begin
                            r_d.fault_act = 1'b1;
                            r_d.clr       = 1'b1;
                        end
                    end
                end
            end
            ST_PUSH: begin
                if (mem_ack_i) begin
                    r_d.sp = push_addr;
                    if (r_q.idx == last_idx) begin
                        r_d.st = ST_VEC;
                    end else begin
                        r_d.idx = r_q.idx + 3'd1;
                    end
                end
            end
            ST_VEC: begin
                if (mem_ack_i) begin
                    r_d.pc_new  = mem_rdata_i;
                    r_d.pc_load = 1'b1;
                    r_d.st      = ST_CHECK;
                end
            end
            ST_CHECK: begin
                r_d.odd  = r_q.pc_new[0];
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            ST_HALT: begin
                r_d.halt = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o     = (r_q.st == ST_PUSH) || (r_q.st == ST_VEC);
    assign mem_we_o      = (r_q.st == ST_PUSH);
    assign mem_long_o    = (r_q.st == ST_VEC) ? 1'b1 : item_long;
    assign mem_addr_o    = (r_q.st == ST_VEC) ? vec_addr : push_addr;
    assign mem_wdata_o   = (r_q.st == ST_PUSH) ? item_data : '0;
    assign sr_o          = r_q.sr_new;
    assign pc_o          = r_q.pc_new;
    assign pc_load_o     = r_q.pc_load;
    assign ssp_o         = r_q.sp;
    assign busy_o        = (r_q.st == ST_PUSH) || (r_q.st == ST_VEC) || (r_q.st == ST_CHECK);
    assign done_o        = r_q.done;
    assign halt_o        = r_q.halt;
    assign odd_pc_o      = r_q.odd;
    assign clr_pending_o = r_q.clr;
endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              fault_i,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic              mem_long_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [ADDR_W-1:0] mem_wdata_o,
    input logic              mem_ack_i,
    input logic [WORD_W-1:0] sr_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic              pc_load_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              halt_o,
    input logic              odd_pc_o,
    input logic              clr_pending_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                       && $stable(mem_long_o) && $stable(mem_wdata_o))); // R10

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o); // R8

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (!mem_req_o && !busy_o)); // R8

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o); // R11

    AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(pc_load_o)); // R7

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o); // R6

    AST_ODD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (odd_pc_o == pc_o[0])); // R7

    AST_SR_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (sr_o[13] && !sr_o[15])); // R5

    AST_CLR_FAULT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pending_o |-> $past(start_i && fault_i)); // R9
endmodule

bind exc_frame_seq exc_frame_seq_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .fault_i       (fault_i),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_long_o    (mem_long_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_ack_i     (mem_ack_i),
    .sr_o          (sr_o),
    .pc_o          (pc_o),
    .pc_load_o     (pc_load_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .halt_o        (halt_o),
    .odd_pc_o      (odd_pc_o),
    .clr_pending_o (clr_pending_o)
);

// File: tb/exc_frame_seq_test.sv
module exc_frame_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        fault_i = 1'b0;
    logic [7:0]  vector_i = '0;
    logic [31:0] pc_i = '0;
    logic [15:0] sr_i = '0;
    logic [15:0] ir_i = '0;
    logic [31:0] fault_addr_i = '0;
    logic [15:0] cycle_info_i = '0;
    logic [31:0] ssp_i = '0;
    logic        fetch_ok_i = 1'b0;
    logic        mem_req_o, mem_we_o, mem_long_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic [15:0] sr_o;
    logic [31:0] pc_o, ssp_o;
    logic        pc_load_o, busy_o, done_o, halt_o, odd_pc_o, clr_pending_o;

    exc_frame_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fault_i(fault_i), .vector_i(vector_i),
        .pc_i(pc_i), .sr_i(sr_i), .ir_i(ir_i), .fault_addr_i(fault_addr_i),
        .cycle_info_i(cycle_info_i), .ssp_i(ssp_i), .fetch_ok_i(fetch_ok_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_long_o(mem_long_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .sr_o(sr_o), .pc_o(pc_o), .pc_load_o(pc_load_o),
        .ssp_o(ssp_o), .busy_o(busy_o), .done_o(done_o), .halt_o(halt_o),
        .odd_pc_o(odd_pc_o), .clr_pending_o(clr_pending_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0;
    int nerr = 0;

    // memory model state
    int          lat = 0;
    int          wcnt = 0;
    logic [31:0] rd_val = '0;
    int          nacc = 0;
    logic [31:0] lg_addr [8];
    logic [31:0] lg_data [8];
    logic        lg_we   [8];
    logic        lg_long [8];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    // memory responder, acts on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack_i) begin
                mem_ack_i = 1'b0;
                wcnt = 0;
            end else if (mem_req_o) begin
                if (wcnt >= lat) begin
                    if (nacc < 8) begin
                        lg_addr[nacc] = mem_addr_o;
                        lg_data[nacc] = mem_wdata_o;
                        lg_we[nacc]   = mem_we_o;
                        lg_long[nacc] = mem_long_o;
                    end
                    nacc++;
                    mem_rdata_i = rd_val;
                    mem_ack_i   = 1'b1;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        report();
    end

    // One complete exception entry with checks. poke: pulse a second start mid-run.
    task automatic run_one(input bit flt, input logic [7:0] vec, input logic [31:0] pc,
                           input logic [15:0] sr, input logic [15:0] ir, input logic [31:0] fa,
                           input logic [15:0] ci, input logic [31:0] ssp, input logic [31:0] newpc,
                           input int latency, input bit poke);
        logic [31:0] items [5];
        logic        longs [5];
        logic [31:0] sp;
        int          n;
        int          waited;
        logic [15:0] exp_sr;
        items[0] = pc;       longs[0] = 1'b1;
        items[1] = {16'h0, sr}; longs[1] = 1'b0;
        items[2] = {16'h0, ir}; longs[2] = 1'b0;
        items[3] = fa;       longs[3] = 1'b1;
        items[4] = {16'h0, ci}; longs[4] = 1'b0;
        n = flt ? 5 : 2;
        exp_sr = (sr | 16'h2000) & 16'h7FFF;

        @(negedge clk);
        lat = latency; rd_val = newpc; nacc = 0;
        fault_i = flt; vector_i = vec; pc_i = pc; sr_i = sr; ir_i = ir;
        fault_addr_i = fa; cycle_info_i = ci; ssp_i = ssp; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R11 busy after start", {31'b0, busy_o}, 32'd1);
        chk("R9 clear pulse", {31'b0, clr_pending_o}, {31'b0, flt});
        if (poke) begin
            @(negedge clk);
            fault_i = 1'b0; vector_i = vec ^ 8'h5A; ssp_i = 32'h0000_8000; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        chk("R7 done seen", {31'b0, done_o}, 32'd1);
        chk("R2/R3 access count", nacc, n + 1);
        sp = ssp;
        for (int i = 0; i < n; i++) begin
            sp = sp - (longs[i] ? 32'd4 : 32'd2);
            if (flt) begin
                chk("R3 write addr", lg_addr[i], sp);
                chk("R3 write data", lg_data[i], items[i]);
                chk("R3 write size", {31'b0, lg_long[i]}, {31'b0, longs[i]});
                chk("R4 write dir", {31'b0, lg_we[i]}, 32'd1);
            end else begin
                chk("R2 write addr", lg_addr[i], sp);
                chk("R2 write data", lg_data[i], items[i]);
                chk("R2 write size", {31'b0, lg_long[i]}, {31'b0, longs[i]});
            end
        end
        chk("R4 final ssp", ssp_o, ssp - (flt ? 32'd14 : 32'd6));
        chk("R6 vector addr", lg_addr[n], {22'h0, vec, 2'b00});
        chk("R6 vector read", {30'b0, lg_we[n], lg_long[n]}, 32'd1);
        chk("R6 new pc", pc_o, newpc);
        chk("R5 new sr", {16'h0, sr_o}, {16'h0, exp_sr});
        chk("R7 odd flag", {31'b0, odd_pc_o}, {31'b0, newpc[0]});
        @(negedge clk);
        chk("R11 idle after done", {30'b0, busy_o, done_o}, 32'd0);
        chk("R7 odd sticky", {31'b0, odd_pc_o}, {31'b0, newpc[0]});
    endtask

    task automatic pulse_fetch_ok();
        @(negedge clk);
        fetch_ok_i = 1'b1;
        @(negedge clk);
        fetch_ok_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs",
            {25'b0, busy_o, done_o, halt_o, odd_pc_o, mem_req_o, pc_load_o, clr_pending_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {30'b0, busy_o, mem_req_o}, 32'd0);

        // sweep both frame types over vectors, stacks, data patterns and latencies
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < 16; k++) begin
                run_one(f[0], 8'(k * 17), 32'h0001_0000 + 32'(k * 2), 16'(k * 16'h1111 ^ 16'hA5C3),
                        16'(16'h4E70 + k), 32'hDEAD_0000 + 32'(k * 3), 16'(16'h0010 + k),
                        32'h0000_2000 + 32'(k * 64), 32'h0000_0400 + 32'(k * 6) + ((k % 3 == 0) ? 32'd1 : 32'd0),
                        k % 3, 1'b0);
                pulse_fetch_ok();
            end
        end

        // R11: a start while busy is ignored
        run_one(1'b0, 8'd9, 32'h1234_5678, 16'hFFFF, 16'h0, 32'h0, 16'h0,
                32'h0000_3000, 32'h0000_0800, 1, 1'b1);

        // R12: trap while a fault is in progress is still handled
        run_one(1'b1, 8'd2, 32'h0000_0100, 16'h8000, 16'h1111, 32'h0000_0055, 16'h0015,
                32'h0000_4000, 32'h0000_0A00, 0, 1'b0);
        run_one(1'b0, 8'd32, 32'h0000_0200, 16'h0700, 16'h0, 32'h0, 16'h0,
                32'h0000_3FF2, 32'h0000_0B00, 2, 1'b0);
        // R12: after fetch_ok a fault is processed normally
        pulse_fetch_ok();
        run_one(1'b1, 8'd3, 32'h0000_0300, 16'h2700, 16'h2222, 32'h0000_0077, 16'h0011,
                32'h0000_5000, 32'h0000_0C01, 1, 1'b0);

        // R8: second fault with the flag still set halts the block
        @(negedge clk);
        nacc = 0; fault_i = 1'b1; vector_i = 8'd2; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 halt raised", {30'b0, halt_o, busy_o}, 32'd2);
        repeat (10) @(negedge clk);
        chk("R8 no access while halted", nacc, 0);
        chk("R8 halt sticky", {31'b0, halt_o}, 32'd1);
        start_i = 1'b1; fault_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 trap ignored while halted", {30'b0, busy_o, mem_req_o}, 32'd0);

        // reset recovers
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears halt", {31'b0, halt_o}, 32'd0);
        rst_n = 1'b1;
        run_one(1'b1, 8'd255, 32'hFFFF_FFFE, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 16'hFFFF,
                32'h0000_000E, 32'hFFFF_FFFF, 0, 1'b0);

        report();
    end
endmodule